// File: doc/BRIEF.md
# Parallel Display Bus Write Sequencer

This block turns a stream of pixel or command words into write cycles on a write-only, 8080-style parallel display bus. A producer offers one word at a time with a valid/ready handshake, together with a two-bit bus format code. The block then runs the strobe sequence for that word on an active-low write strobe (`wr_n`), a latch strobe (`latch`) and a parallel data bus (`db`).

Three bus formats are supported:

- **Narrow.** A byte goes out on the low lanes.
- **Wide.** A full word goes out on all lanes.
- **Split.** A full word crosses the low lanes in two halves. An external latch captures the first half on the `latch` pulse, and both halves reach the panel within one low period of `wr_n`.

Four duration inputs set how many clocks each part of the sequence lasts: setup, strobe-low, latch-high and recovery. The bus lanes are driven by a register that only toggles bits whose value differs from what the lanes already carry. A repeated word still produces a complete strobe.

Top module: `pbus_writer`

## Requirements
- R1: After reset `wr_n` is 1, `latch` is 0, `db` is all zeros and `in_ready` is 1.
- R2: `in_ready` is 1 only when no sequence is running. A word is taken on a rising clock edge with `in_valid` and `in_ready` both 1. `wr_n` is 0 from the next cycle on, and `in_ready` returns to 1 only after the recovery part has ended.
- R3: Format code 0 (narrow): `wr_n` falls while `db` still carries the previous value. `db[7:0]` then takes the low byte of the word while `db[15:8]` keep their value. `wr_n` then rises.
- R4: Format code 1 (wide), and code 3, which behaves the same: `wr_n` falls, `db[15:0]` then takes the whole word, and `wr_n` then rises.
- R5: Format code 2 (split), in this order:
  - `wr_n` falls.
  - `db[7:0]` takes the word's low byte.
  - `latch` is 1 for the latch part and then returns to 0.
  - `db[7:0]` takes the high byte while `wr_n` is still 0.
  - Only after that does `wr_n` rise.
  - `db[15:8]` keep their value throughout.
- R6: Each part lasts its programmed number of clocks, with a programmed 0 treated as 1:
  - setup: `wr_n` low, old data on `db`
  - strobe-low: `wr_n` low, new data on `db`; this part occurs twice in split format
  - latch-high
  - recovery: `wr_n` high, `in_ready` 0
- R7: A word equal to the value already on the bus still produces the complete strobe sequence of its format.
- R8: `db` changes only in a cycle where `wr_n` has already been 0 for at least one cycle.
- R9: `latch` is 1 only while `wr_n` is 0 and the word in progress uses format code 2.
- R10: While idle with `in_valid` at 0, `wr_n`, `latch` and `db` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Word offered |
| in_ready | output | 1 | Block idle, word can be taken |
| in_word | input | BUS_W (16) | Word to write |
| in_fmt | input | 2 | Bus format: 0 narrow, 1 wide, 2 split, 3 wide |
| cfg_setup | input | CNT_W (8) | Setup clocks (0 means 1) |
| cfg_low | input | CNT_W (8) | Strobe-low clocks per data phase (0 means 1) |
| cfg_latch | input | CNT_W (8) | Latch-high clocks (0 means 1) |
| cfg_hold | input | CNT_W (8) | Recovery clocks after `wr_n` rises (0 means 1) |
| wr_n | output | 1 | Active-low write strobe |
| latch | output | 1 | High-byte latch strobe for split format |
| db | output | BUS_W (16) | Data bus lanes |

## Verification
The bench follows every accepted word cycle by cycle against a lane-history model. It targets the following corner cases:

- **Narrow words.** The upper lanes must keep the previous value; a design that cleared them would be caught on the next narrow word.
- **Split words.** The low byte must come before the high byte and the latch pulse must sit between them; a swapped order or a latch pulse after `wr_n` rises would mismatch at the exact cycle.
- **Zero durations.** Every duration set to zero must give one-clock parts; a counter that wrapped would stall for 256 clocks and trip the per-cycle check.
- **Repeated words and format code 3.** A repeated word must still strobe, and code 3 must act as wide; skipping the strobe on an unchanged word, or treating code 3 as narrow, both show up at the ports.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SETUP,
      ST_DRIVE,
      ST_LATCH,
      ST_DRIVE2,
      ST_HOLD
   } pbus_state_t;

   localparam logic [1:0] FMT_NARROW = 2'd0;
   localparam logic [1:0] FMT_WIDE   = 2'd1;
   localparam logic [1:0] FMT_SPLIT  = 2'd2;
endpackage

// File: rtl/pbus_phase_timer.sv
module pbus_phase_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] len,
   output logic             done
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= (len == '0) ? '0 : len - 1'b1;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign done = (cnt_q == '0);
endmodule

// File: rtl/pbus_lane_reg.sv
module pbus_lane_reg #(
   parameter int BUS_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [BUS_W-1:0] nxt,
   output logic [BUS_W-1:0] lanes
);
   logic [BUS_W-1:0] lane_q;

   for (genvar b = 0; b < BUS_W; b++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            lane_q[b] <= 1'b0;
         else if (load && (nxt[b] != lane_q[b]))
            lane_q[b] <= nxt[b];
      end
   end

   assign lanes = lane_q;
endmodule

// File: rtl/pbus_writer.sv
module pbus_writer
   import pbus_pkg::*;
#(
   parameter int BUS_W = 16,
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [BUS_W-1:0] in_word,
   input  logic [1:0]       in_fmt,
   input  logic [CNT_W-1:0] cfg_setup,
   input  logic [CNT_W-1:0] cfg_low,
   input  logic [CNT_W-1:0] cfg_latch,
   input  logic [CNT_W-1:0] cfg_hold,
   output logic             wr_n,
   output logic             latch,
   output logic [BUS_W-1:0] db
);
   localparam int HALF_W = BUS_W / 2;

   if ((BUS_W % 2) != 0 || BUS_W < 2) begin : g_bad_bus
      $error("pbus_writer: BUS_W must be even and at least 2");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("pbus_writer: CNT_W must be at least 1");
   end

   pbus_state_t      state_q, state_d;
   logic [BUS_W-1:0] word_q;
   logic [1:0]       mode_q;
   logic             t_load, t_done, lane_load;
   logic [CNT_W-1:0] t_len;
   logic [BUS_W-1:0] lane_nxt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         word_q  <= '0;
         mode_q  <= FMT_NARROW;
      end else begin
         state_q <= state_d;
         if (state_q == ST_IDLE && in_valid) begin
            word_q <= in_word;
            mode_q <= in_fmt;
         end
      end
   end

   always_comb begin
      state_d   = state_q;
      t_load    = 1'b0;
      t_len     = '0;
      lane_load = 1'b0;
      lane_nxt  = db;
      unique case (state_q)
         ST_IDLE: if (in_valid) begin
            state_d = ST_SETUP;
            t_load  = 1'b1;
            t_len   = cfg_setup;
         end
         ST_SETUP: if (t_done) begin
            state_d   = ST_DRIVE;
            t_load    = 1'b1;
            t_len     = cfg_low;
            lane_load = 1'b1;
            if (mode_q == FMT_NARROW || mode_q == FMT_SPLIT)
               lane_nxt = {db[BUS_W-1:HALF_W], word_q[HALF_W-1:0]};
            else
               lane_nxt = word_q;
         end
         ST_DRIVE: if (t_done) begin
            t_load = 1'b1;
            if (mode_q == FMT_SPLIT) begin
               state_d = ST_LATCH;
               t_len   = cfg_latch;
            end else begin
               state_d = ST_HOLD;
               t_len   = cfg_hold;
            end
         end
         ST_LATCH: if (t_done) begin
            state_d   = ST_DRIVE2;
            t_load    = 1'b1;
            t_len     = cfg_low;
            lane_load = 1'b1;
            lane_nxt  = {db[BUS_W-1:HALF_W], word_q[BUS_W-1:HALF_W]};
         end
         ST_DRIVE2: if (t_done) begin
            state_d = ST_HOLD;
            t_load  = 1'b1;
            t_len   = cfg_hold;
         end
         ST_HOLD: if (t_done) state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   pbus_phase_timer #(.CNT_W(CNT_W)) u_timer (
      .clk  (clk),
      .rst_n(rst_n),
      .load (t_load),
      .len  (t_len),
      .done (t_done)
   );

   pbus_lane_reg #(.BUS_W(BUS_W)) u_lanes (
      .clk  (clk),
      .rst_n(rst_n),
      .load (lane_load),
      .nxt  (lane_nxt),
      .lanes(db)
   );

   assign in_ready = (state_q == ST_IDLE);
   assign wr_n     = (state_q == ST_IDLE) || (state_q == ST_HOLD);
   assign latch    = (state_q == ST_LATCH);
endmodule

// File: rtl/pbus_writer_chk.sv
module pbus_writer_chk #(
   parameter int BUS_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             in_ready,
   input logic             wr_n,
   input logic             latch,
   input logic [BUS_W-1:0] db,
   input logic [1:0]       mode_q
);
   // R2
   busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_n |-> !in_ready);

   // R2
   accept_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> (!wr_n && !in_ready));

   // R8
   data_settled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(db) |-> (!wr_n && !$past(wr_n)));

   // R9
   latch_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      latch |-> (!wr_n && mode_q == 2'd2));

   // R5
   latch_before_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wr_n) |-> !$past(latch));
endmodule

bind pbus_writer pbus_writer_chk #(.BUS_W(BUS_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .in_valid(in_valid),
   .in_ready(in_ready),
   .wr_n    (wr_n),
   .latch   (latch),
   .db      (db),
   .mode_q  (mode_q)
);

// File: tb/pbus_writer_bench.sv
module pbus_writer_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [15:0] in_word = '0;
   logic [1:0]  in_fmt = '0;
   logic [7:0]  cfg_setup = 8'd1, cfg_low = 8'd1, cfg_latch = 8'd1, cfg_hold = 8'd1;
   logic        wr_n, latch;
   logic [15:0] db;

   int total = 0;
   int bad = 0;
   bit finished = 0;
   logic [15:0] prev_db = '0;

   always #2 clk = ~clk;

   pbus_writer u_pbus_writer (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_word(in_word), .in_fmt(in_fmt), .cfg_setup(cfg_setup), .cfg_low(cfg_low),
      .cfg_latch(cfg_latch), .cfg_hold(cfg_hold), .wr_n(wr_n), .latch(latch), .db(db)
   );

   task automatic chk(input string req, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic int eff(input logic [7:0] v);
      return (v == 8'd0) ? 1 : int'(v);
   endfunction

   task automatic step(input string req, input int n, input logic ew, input logic el,
                       input logic [15:0] ed);
      for (int i = 0; i < n; i++) begin
         chk(req, "wr_n", {31'd0, wr_n}, {31'd0, ew});
         chk(req, "latch", {31'd0, latch}, {31'd0, el});
         chk(req, "db", {16'd0, db}, {16'd0, ed});
         chk("R2", "in_ready busy", {31'd0, in_ready}, 32'd0);
         @(negedge clk);
      end
   endtask

   // Called at a negedge with the block idle; returns at the negedge it is idle again.
   task automatic send(input string req, input logic [15:0] w, input logic [1:0] f);
      int s, l, t, h;
      logic [15:0] n1, n2;
      s = eff(cfg_setup); l = eff(cfg_low); t = eff(cfg_latch); h = eff(cfg_hold);
      chk("R2", "ready before", {31'd0, in_ready}, 32'd1);
      in_valid = 1'b1; in_word = w; in_fmt = f;
      @(negedge clk);
      in_valid = 1'b0; in_word = $urandom; in_fmt = 2'($urandom);
      if (f == 2'd0) begin
         n1 = {prev_db[15:8], w[7:0]}; n2 = n1;
      end else if (f == 2'd2) begin
         n1 = {prev_db[15:8], w[7:0]}; n2 = {prev_db[15:8], w[15:8]};
      end else begin
         n1 = w; n2 = w;
      end
      step(req, s, 1'b0, 1'b0, prev_db);
      step(req, l, 1'b0, 1'b0, n1);
      if (f == 2'd2) begin
         step(req, t, 1'b0, 1'b1, n1);
         step(req, l, 1'b0, 1'b0, n2);
      end
      step(req, h, 1'b1, 1'b0, n2);
      chk("R2", "ready after", {31'd0, in_ready}, 32'd1);
      chk(req, "wr_n idle", {31'd0, wr_n}, 32'd1);
      prev_db = n2;
   endtask

   initial begin
      void'($urandom(32'h5eed_1234));
      repeat (3) @(negedge clk);
      // R1
      chk("R1", "wr_n", {31'd0, wr_n}, 32'd1);
      chk("R1", "latch", {31'd0, latch}, 32'd0);
      chk("R1", "db", {16'd0, db}, 32'd0);
      chk("R1", "in_ready", {31'd0, in_ready}, 32'd1);
      rst_n = 1'b1;
      @(negedge clk);

      send("R4", 16'hA55A, 2'd1);
      send("R3", 16'h1234, 2'd0);   // upper lanes keep 8'hA5
      send("R5", 16'hBEEF, 2'd2);
      send("R4", 16'h0F0F, 2'd3);   // code 3 acts as wide

      // R6: all durations zero mean one clock
      cfg_setup = 0; cfg_low = 0; cfg_latch = 0; cfg_hold = 0;
      send("R6", 16'hC3C3, 2'd2);
      send("R6", 16'h3C3C, 2'd1);
      cfg_setup = 3; cfg_low = 4; cfg_latch = 2; cfg_hold = 5;
      send("R6", 16'h7E81, 2'd2);

      // R7: repeated identical word
      send("R7", prev_db, 2'd1);
      send("R7", prev_db, 2'd1);

      // R10: idle with in_valid low
      for (int i = 0; i < 6; i++) begin
         in_word = $urandom; in_fmt = 2'($urandom);
         @(negedge clk);
         chk("R10", "db idle", {16'd0, db}, {16'd0, prev_db});
         chk("R10", "wr_n idle", {31'd0, wr_n}, 32'd1);
         chk("R10", "latch idle", {31'd0, latch}, 32'd0);
      end

      for (int k = 0; k < 150; k++) begin
         logic [1:0] f;
         cfg_setup = 8'($urandom_range(0, 3));
         cfg_low   = 8'($urandom_range(0, 3));
         cfg_latch = 8'($urandom_range(0, 3));
         cfg_hold  = 8'($urandom_range(0, 3));
         f = 2'($urandom);
         send(f == 2'd0 ? "R3" : (f == 2'd2 ? "R5" : "R4"), 16'($urandom), f);
      end

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         bad++;
         total++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule